// File: doc/BRIEF.md
# Index-Prefix Register Substitution Decoder

This decoder stage watches a stream of instruction bytes, one per cycle when `in_valid` is high. An index prefix byte (0xDD for the X index register, 0xFD for the Y index register) emits nothing. It arms a substitution for the next op byte only. While a prefix is armed, an operand selector that names H or L in the next op is replaced by the high or low half of the chosen index register. The groups covered are register-to-register loads, increment, decrement, immediate loads and the eight accumulator ALU operations.

Each op byte produces one registered result: an operation kind, an ALU function code, a destination selector, a source selector and a flag that says a prefix was applied. An immediate load takes the following byte as its data. That byte comes out on a separate strobe and is never decoded as an op or a prefix. The decoder does not execute anything. It also does not fetch the displacement byte that memory forms would use.

Top module: `ixsub_decoder`

## Requirements
- R1: After reset, `op_valid`, `imm_valid` and `pfx_active` are 0, and no prefix is armed.
- R2: An accepted 0xDD or 0xFD byte (while no immediate is pending) produces neither strobe. 0xDD arms the X index register and 0xFD arms the Y index register for the next op byte. Idle cycles do not disarm the prefix.
- R3: Operand fields in op bits 5:3 and 2:0 are coded B=000, C=001, D=010, E=011, H=100, L=101, memory=110, A=111. A selector output equals the field value (0 to 7) when it is not substituted. The index halves are X-high=8, X-low=9, Y-high=10 and Y-low=11. An operand that is not used reads 15.
- R4: Op bytes 0x40 to 0x7F, except 0x76, are loads (kind 1) with destination from bits 5:3 and source from bits 2:0. Under a prefix, H and L are substituted in both operands together. For example, prefix 0xDD with 0x64 gives dst 8 and src 8, and with 0x65 gives dst 8 and src 9.
- R5: Op bytes 00rrr100 are increments (kind 2) and 00rrr101 are decrements (kind 3). For both, destination and source are the substituted field rrr.
- R6: Op bytes 00rrr110 are immediate loads (kind 4) with the substituted rrr as destination and source 15. The next accepted byte is output on `imm_data` with `imm_valid` one cycle later. That byte yields no `op_valid` and arms no prefix, even if its value is 0xDD or 0xFD.
- R7: Op bytes 10fffrrr are ALU operations (kind 5) with `alu_fn`=fff: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 and, 5 xor, 6 or, 7 compare. The destination is A (7) and the source is the substituted rrr. `alu_fn` is 0 for every other kind.
- R8: In a load where one operand field is 110, an H or L in the other field is not substituted.
- R9: A prefix applies to exactly one op byte. The following op decodes unsubstituted, with `pfx_active` 0.
- R10: When prefixes follow each other, the last one accepted decides the index register.
- R11: Every other op byte (0x76, the rest of 0x00 to 0x3F, and 0xC0 to 0xFF other than the prefixes) gives kind 0 with both selectors 15. It still consumes an armed prefix and reports it on `pfx_active`.
- R12: A cycle with `in_valid` low produces no strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Instruction stream byte |
| op_valid | output | 1 | One-cycle strobe: a decoded op is on the outputs |
| op_kind | output | 3 | 0 other, 1 load, 2 increment, 3 decrement, 4 immediate load, 5 ALU |
| alu_fn | output | 3 | ALU function code for kind 5, else 0 |
| dst_sel | output | 4 | Destination selector (R3 coding) |
| src_sel | output | 4 | Source selector (R3 coding) |
| pfx_active | output | 1 | A prefix was applied to this op |
| imm_valid | output | 1 | One-cycle strobe: immediate byte on `imm_data` |
| imm_data | output | 8 | Immediate operand byte |

## Verification
Every result is registered once. An op byte, or an immediate byte, accepted at a rising edge shows up on the outputs just after that edge and stays there for exactly one cycle. A prefix byte shows nothing in that slot. The bench drives each byte on a falling edge and drops `in_valid` on the next falling edge. It reads the outputs at that same falling edge, half a cycle after the edge that captured the byte. Every opcode is swept under no prefix, the X prefix and the Y prefix, with the expected kind and selectors worked out from the bit fields. Directed sequences then cover idle gaps, stacked prefixes and prefix-valued immediates.

// File: rtl/ixsub_pkg.sv
package ixsub_pkg;
  localparam int OP_W  = 8;
  localparam int SEL_W = 4;
  localparam int FLD_W = 3;

  localparam logic [FLD_W-1:0] FLD_H   = 3'b100;
  localparam logic [FLD_W-1:0] FLD_L   = 3'b101;
  localparam logic [FLD_W-1:0] FLD_MEM = 3'b110;
  localparam logic [FLD_W-1:0] FLD_A   = 3'b111;

  localparam logic [SEL_W-1:0] SEL_NONE    = 4'd15;
  localparam logic [SEL_W-1:0] IDX_BASE_IX = 4'd8;
  localparam logic [SEL_W-1:0] IDX_BASE_IY = 4'd10;

  typedef enum logic [1:0] {PFX_NONE = 2'd0, PFX_IX = 2'd1, PFX_IY = 2'd2} pfx_e;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0, K_LOAD = 3'd1, K_INC = 3'd2,
    K_DEC   = 3'd3, K_LDIMM = 3'd4, K_ALU = 3'd5
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [FLD_W-1:0] fn;
    logic [FLD_W-1:0] dst_fld;
    logic [FLD_W-1:0] src_fld;
    logic             dst_use;
    logic             src_use;
    logic             dst_peer_mem;
    logic             src_peer_mem;
    logic             need_imm;
  } opinfo_t;

  // Substitute H/L by an index half when a prefix is armed and the peer
  // operand is not the memory field.
  function automatic logic [SEL_W-1:0] map_sel(input logic [FLD_W-1:0] fld,
                                               input logic peer_mem,
                                               input pfx_e p);
    logic [SEL_W-1:0] base;
    base = (p == PFX_IY) ? IDX_BASE_IY : IDX_BASE_IX;
    if (p != PFX_NONE && !peer_mem && (fld == FLD_H || fld == FLD_L))
      return base + {{(SEL_W-1){1'b0}}, fld[0]};
    return {1'b0, fld};
  endfunction
endpackage

// File: rtl/ixsub_classify.sv
module ixsub_classify
  import ixsub_pkg::*;
(
  input  logic [OP_W-1:0] op_byte,
  output opinfo_t         info
);
  localparam logic [OP_W-1:0] HALT_CODE = 8'h76;

  logic [FLD_W-1:0] hi_fld;
  logic [FLD_W-1:0] lo_fld;
  assign hi_fld = op_byte[5:3];
  assign lo_fld = op_byte[2:0];

  always_comb begin
    info = '0;
    info.kind    = K_OTHER;
    info.dst_fld = hi_fld;
    info.src_fld = lo_fld;
    unique case (op_byte[7:6])
      2'b01: begin
        if (op_byte != HALT_CODE) begin
          info.kind         = K_LOAD;
          info.dst_use      = 1'b1;
          info.src_use      = 1'b1;
          info.dst_peer_mem = (lo_fld == FLD_MEM);
          info.src_peer_mem = (hi_fld == FLD_MEM);
        end
      end
      2'b10: begin
        info.kind    = K_ALU;
        info.fn      = hi_fld;
        info.dst_fld = FLD_A;
        info.dst_use = 1'b1;
        info.src_use = 1'b1;
      end
      2'b00: begin
        unique case (lo_fld)
          3'b100: begin
            info.kind = K_INC; info.src_fld = hi_fld;
            info.dst_use = 1'b1; info.src_use = 1'b1;
          end
          3'b101: begin
            info.kind = K_DEC; info.src_fld = hi_fld;
            info.dst_use = 1'b1; info.src_use = 1'b1;
          end
          3'b110: begin
            info.kind = K_LDIMM; info.dst_use = 1'b1; info.need_imm = 1'b1;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ixsub_pfx_track.sv
module ixsub_pfx_track
  import ixsub_pkg::*;
#(
  parameter logic [OP_W-1:0] IX_CODE = 8'hDD,
  parameter logic [OP_W-1:0] IY_CODE = 8'hFD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_byte,
  input  logic            need_imm,
  output pfx_e            cur_pfx,
  output logic            is_op,
  output logic            is_imm
);
  pfx_e pfx_q;
  logic imm_pend_q;
  logic is_pfx;

  assign is_imm  = in_valid && imm_pend_q;
  assign is_pfx  = in_valid && !imm_pend_q && (in_byte == IX_CODE || in_byte == IY_CODE);
  assign is_op   = in_valid && !imm_pend_q && !is_pfx;
  assign cur_pfx = pfx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_q      <= PFX_NONE;
      imm_pend_q <= 1'b0;
    end else if (is_imm) begin
      imm_pend_q <= 1'b0;
    end else if (is_pfx) begin
      pfx_q <= (in_byte == IX_CODE) ? PFX_IX : PFX_IY;
    end else if (is_op) begin
      pfx_q      <= PFX_NONE;
      imm_pend_q <= need_imm;
    end
  end

  AST_PFX_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    is_op |=> (cur_pfx == PFX_NONE)); // R9
  AST_IMM_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    is_imm |=> !imm_pend_q); // R6
  AST_IDLE_KEEPS_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pfx_q)); // R2
endmodule

// File: rtl/ixsub_decoder.sv
module ixsub_decoder
  import ixsub_pkg::*;
#(
  parameter logic [7:0] IX_CODE = 8'hDD,
  parameter logic [7:0] IY_CODE = 8'hFD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       op_valid,
  output logic [2:0] op_kind,
  output logic [2:0] alu_fn,
  output logic [3:0] dst_sel,
  output logic [3:0] src_sel,
  output logic       pfx_active,
  output logic       imm_valid,
  output logic [7:0] imm_data
);
  localparam int N_OPND = 2;

  opinfo_t          info;
  pfx_e             cur_pfx;
  logic             is_op;
  logic             is_imm;
  logic [FLD_W-1:0] opnd_fld  [N_OPND];
  logic             opnd_use  [N_OPND];
  logic             opnd_peer [N_OPND];
  logic [SEL_W-1:0] opnd_sel  [N_OPND];

  ixsub_classify u_cls (.op_byte(in_byte), .info(info));

  ixsub_pfx_track #(.IX_CODE(IX_CODE), .IY_CODE(IY_CODE)) u_trk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .need_imm(info.need_imm), .cur_pfx(cur_pfx), .is_op(is_op), .is_imm(is_imm)
  );

  // index 0 = destination, 1 = source
  assign opnd_fld[0]  = info.dst_fld;
  assign opnd_use[0]  = info.dst_use;
  assign opnd_peer[0] = info.dst_peer_mem;
  assign opnd_fld[1]  = info.src_fld;
  assign opnd_use[1]  = info.src_use;
  assign opnd_peer[1] = info.src_peer_mem;

  for (genvar g = 0; g < N_OPND; g++) begin : g_remap
    assign opnd_sel[g] = opnd_use[g] ? map_sel(opnd_fld[g], opnd_peer[g], cur_pfx)
                                     : SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid   <= 1'b0;
      imm_valid  <= 1'b0;
      op_kind    <= K_OTHER;
      alu_fn     <= '0;
      dst_sel    <= SEL_NONE;
      src_sel    <= SEL_NONE;
      pfx_active <= 1'b0;
      imm_data   <= '0;
    end else begin
      op_valid  <= is_op;
      imm_valid <= is_imm;
      if (is_op) begin
        op_kind    <= info.kind;
        alu_fn     <= info.fn;
        dst_sel    <= opnd_sel[0];
        src_sel    <= opnd_sel[1];
        pfx_active <= (cur_pfx != PFX_NONE);
      end
      if (is_imm) imm_data <= in_byte;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && imm_valid)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!op_valid && !imm_valid)); // R12
  AST_PLAIN_NO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !pfx_active) |-> (src_sel < IDX_BASE_IX || src_sel == SEL_NONE)
                               && (dst_sel < IDX_BASE_IX || dst_sel == SEL_NONE)); // R9
  AST_MEM_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == K_LOAD && (src_sel == 4'd6 || dst_sel == 4'd6))
      |-> (src_sel < IDX_BASE_IX && dst_sel < IDX_BASE_IX)); // R8
endmodule

// File: tb/ixsub_decoder_tb.sv
module ixsub_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       op_valid, pfx_active, imm_valid;
  logic [2:0] op_kind, alu_fn;
  logic [3:0] dst_sel, src_sel;
  logic [7:0] imm_data;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ixsub_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .op_valid(op_valid), .op_kind(op_kind), .alu_fn(alu_fn), .dst_sel(dst_sel),
    .src_sel(src_sel), .pfx_active(pfx_active), .imm_valid(imm_valid), .imm_data(imm_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // byte applied at a falling edge, captured at the rising edge, read at the next falling edge
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int sub(input int f, input bit blocked, input int p);
    if (p == 0 || blocked || f < 4 || f > 5) return f;
    return ((p == 1) ? 8 : 10) + (f - 4);
  endfunction

  task automatic sweep_one(input int p, input int op);
    int hi, lo, ek, ef, ed, es;
    string tg;
    hi = (op / 8) % 8;
    lo = op % 8;
    ek = 0; ef = 0; ed = 15; es = 15; tg = "R11";
    if (op >= 64 && op < 128 && op != 118) begin
      ek = 1; ed = sub(hi, lo == 6, p); es = sub(lo, hi == 6, p);
      tg = (lo == 6 || hi == 6) ? "R8" : "R4";
    end else if (op >= 128 && op < 192) begin
      ek = 5; ef = hi; ed = 7; es = sub(lo, 1'b0, p); tg = "R7";
    end else if (op < 64 && lo == 4) begin
      ek = 2; ed = sub(hi, 1'b0, p); es = ed; tg = "R5";
    end else if (op < 64 && lo == 5) begin
      ek = 3; ed = sub(hi, 1'b0, p); es = ed; tg = "R5";
    end else if (op < 64 && lo == 6) begin
      ek = 4; ed = sub(hi, 1'b0, p); tg = "R6";
    end
    if (p == 1) send(8'hDD);
    else if (p == 2) send(8'hFD);
    send(op[7:0]);
    chk(tg, op_valid, 1);
    chk(tg, op_kind, ek);
    chk(tg, alu_fn, ef);
    chk(tg, dst_sel, ed);
    chk(tg, src_sel, es);
    chk("R2", pfx_active, (p != 0) ? 1 : 0);
    if (ek == 4) begin
      send(op[7:0] ^ 8'hA5);
      chk("R6", imm_valid, 1);
      chk("R6", op_valid, 0);
      chk("R6", imm_data, (op ^ 8'hA5) & 8'hFF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", op_valid, 0);
    chk("R1", imm_valid, 0);
    chk("R1", pfx_active, 0);
    send(8'h7C);
    chk("R1", src_sel, 4);

    send(8'h78);
    chk("R3", dst_sel, 7);
    chk("R3", src_sel, 0);

    send(8'hDD);
    chk("R2", op_valid, 0);
    chk("R2", imm_valid, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R12", op_valid, 0);
    end
    send(8'h7C);
    chk("R2", src_sel, 8);
    send(8'h7C);
    chk("R9", src_sel, 4);
    chk("R9", pfx_active, 0);

    send(8'hDD); send(8'h64);
    chk("R4", dst_sel, 8); chk("R4", src_sel, 8);
    send(8'hDD); send(8'h65);
    chk("R4", dst_sel, 8); chk("R4", src_sel, 9);
    send(8'hDD); send(8'h66);
    chk("R8", dst_sel, 4); chk("R8", src_sel, 6);
    send(8'hFD); send(8'h74);
    chk("R8", dst_sel, 6); chk("R8", src_sel, 4);

    send(8'hDD); send(8'hFD); send(8'h65);
    chk("R10", dst_sel, 10); chk("R10", src_sel, 11);
    send(8'hFD); send(8'hDD); send(8'h44);
    chk("R10", dst_sel, 0); chk("R10", src_sel, 8);

    send(8'hDD); send(8'h26); send(8'hDD);
    chk("R6", imm_valid, 1); chk("R6", op_valid, 0); chk("R6", imm_data, 8'hDD);
    send(8'h7C);
    chk("R6", src_sel, 4); chk("R6", pfx_active, 0);

    send(8'hFD); send(8'hC9);
    chk("R11", op_kind, 0); chk("R11", pfx_active, 1);
    send(8'h65);
    chk("R11", dst_sel, 4); chk("R11", src_sel, 5);

    for (int p = 0; p < 3; p++) begin
      for (int op = 0; op < 256; op++) begin
        if (op != 8'hDD && op != 8'hFD) sweep_one(p, op);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule